// File: doc/BRIEF.md
# Dual-Group Frequency Window Lock Checker

The block decides whether a divided oscillator runs at its intended rate. It measures against a steady reference clock. The reference clock marks off a fixed window of `WIN_CYCLES` cycles, 32 by default, which is 1.28 µs at 25 MHz. During the window the block counts the oscillator edges, which arrive as one-cycle pulses already synchronized into the reference domain. An oscillator at F GHz then gives about F × 1280 edges per window.

At the end of each window the final count is compared against two programmed targets, group 0 and group 1. Each target is a 15-bit expected count. Its low byte sits in one input. Its upper seven bits sit in bits 6:0 of a second input, whose bit 7 turns that group's comparison on. A single tolerance byte supplies two nibbles, one per group. Each nibble is an absolute allowance in counts, so the allowance in ppm is 1e6 × tol / expected.

The block reports three results together with a one-cycle done pulse:
- the raw count;
- one match flag per group;
- the done pulse itself, which repeats every window for as long as the restart control is low.

For single-frequency use, both groups are loaded with the same values.

Top module: `freq_window_checker`

## Requirements
- R1: While `rst` or `restart` is high, `done`, `match` and `count` are all zero on the following cycle.
- R2: After `restart` is sampled low, the first `done` pulse appears right after the `WIN_CYCLES`-th rising edge that samples `restart` low. The pulse lasts one cycle. Further pulses follow every `WIN_CYCLES` cycles with no gap between windows.
- R3: With `done`, `count` equals the number of rising edges in the window at which `osc_pulse` was sampled high.
- R4: The expected count of group g is {`expg_hi`[6:0], `expg_lo`[7:0]}, sampled at the window's last edge. Both bytes take part in the comparison.
- R5: Group 0 uses tolerance `tol_byte`[3:0] and group 1 uses `tol_byte`[7:4]. A group matches when |count − expected| ≤ its tolerance, whether the count lies above or below the expected value. `match`[0] is group 0 and `match`[1] is group 1.
- R6: A group whose `expg_hi`[7] is 0 at the window's last edge never matches, even if the count is equal to its expected value.
- R7: The edge count saturates at 0x7FFF instead of wrapping.
- R8: Raising `restart` in mid-window discards the partial count. The window after release counts only pulses that arrive after the release.
- R9: Between `done` pulses, `count` and `match` hold the values reported with the last `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| restart | input | 1 | Holds the measurement while high; a fresh window starts on release |
| osc_pulse | input | 1 | One-cycle pulse per oscillator edge, synchronous to `clk` |
| exp0_lo | input | 8 | Group 0 expected count, bits 7:0 |
| exp0_hi | input | 8 | Group 0: bit 7 enable, bits 6:0 expected count bits 14:8 |
| exp1_lo | input | 8 | Group 1 expected count, bits 7:0 |
| exp1_hi | input | 8 | Group 1: bit 7 enable, bits 6:0 expected count bits 14:8 |
| tol_byte | input | 8 | Bits 3:0 tolerance of group 0, bits 7:4 tolerance of group 1 |
| match | output | 2 | Per-group match flags, valid with `done` and held afterwards |
| count | output | 15 | Edge count of the last completed window |
| done | output | 1 | One-cycle pulse at the end of each window |

## Verification
The windows are driven with random pulse densities, from empty to full. This shows whether the count follows each edge or drifts by one at the window boundaries. Targets are placed exactly at count ± tolerance and one step beyond, on both sides and with both nibbles. These cases separate an inclusive comparison from an exclusive one, and they also catch nibbles swapped between the groups. Other directed cases cover:
- a target that differs only in the high byte;
- a disabled group whose target equals the count exactly;
- a restart in mid-window;
- a second instance with a long window, driven with a pulse on every cycle so that the 15-bit limit is crossed.

// File: rtl/fwc_pkg.sv
package fwc_pkg;
    localparam int BYTE_W  = 8;
    localparam int CNT_W   = 2 * BYTE_W - 1;
    localparam int TOL_W   = 4;
    localparam int NGRP    = 2;

    typedef logic [CNT_W-1:0] cnt_t;
    localparam cnt_t CNT_MAX = '1;

    typedef struct packed {
        logic             en;
        cnt_t             expect_cnt;
        logic [TOL_W-1:0] tol;
    } grp_cfg_t;

    function automatic grp_cfg_t unpack_cfg(input logic [BYTE_W-1:0] lo,
                                            input logic [BYTE_W-1:0] hi,
                                            input logic [TOL_W-1:0]  tol);
        grp_cfg_t r;
        r.en         = hi[BYTE_W-1];
        r.expect_cnt = {hi[BYTE_W-2:0], lo};
        r.tol        = tol;
        return r;
    endfunction

    function automatic logic within_tol(input cnt_t c, input cnt_t e,
                                        input logic [TOL_W-1:0] tol);
        cnt_t d;
        d = (c >= e) ? (c - e) : (e - c);
        return d <= cnt_t'(tol);
    endfunction
endpackage

// File: rtl/fwc_window_ctrl.sv
module fwc_window_ctrl #(
    parameter int WIN_CYCLES = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic hold_i,
    output logic last_o
);
    localparam int WC_W = (WIN_CYCLES > 2) ? $clog2(WIN_CYCLES) : 1;
    localparam logic [WC_W-1:0] WC_LAST = WC_W'(WIN_CYCLES - 1);

    logic [WC_W-1:0] wc;

    always_ff @(posedge clk) begin
        if (rst || hold_i) begin
            wc <= '0;
        end else if (wc == WC_LAST) begin
            wc <= '0;
        end else begin
            wc <= wc + 1'b1;
        end
    end

    assign last_o = !hold_i && (wc == WC_LAST);

    assert_wc_range_R2: assert property (@(posedge clk) disable iff (rst)
        wc <= WC_LAST);
endmodule

// File: rtl/fwc_edge_counter.sv
module fwc_edge_counter
    import fwc_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic clr_i,
    input  logic inc_i,
    output cnt_t acc_o,
    output cnt_t next_o
);
    cnt_t acc;

    always_comb begin
        if (acc == CNT_MAX) next_o = acc;
        else                next_o = acc + cnt_t'(inc_i);
    end

    always_ff @(posedge clk) begin
        if (rst || clr_i) acc <= '0;
        else              acc <= next_o;
    end

    assign acc_o = acc;

    assert_no_wrap_R7: assert property (@(posedge clk) disable iff (rst)
        (acc == CNT_MAX && !clr_i) |=> (acc == CNT_MAX));
endmodule

// File: rtl/fwc_group_cmp.sv
module fwc_group_cmp
    import fwc_pkg::*;
(
    input  grp_cfg_t cfg_i,
    input  cnt_t     cnt_i,
    output logic     hit_o
);
    assign hit_o = cfg_i.en && within_tol(cnt_i, cfg_i.expect_cnt, cfg_i.tol);
endmodule

// File: rtl/freq_window_checker.sv
module freq_window_checker
    import fwc_pkg::*;
#(
    parameter int WIN_CYCLES = 32
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        restart,
    input  logic        osc_pulse,
    input  logic [7:0]  exp0_lo,
    input  logic [7:0]  exp0_hi,
    input  logic [7:0]  exp1_lo,
    input  logic [7:0]  exp1_hi,
    input  logic [7:0]  tol_byte,
    output logic [1:0]  match,
    output logic [14:0] count,
    output logic        done
);
    localparam int BOUND = (WIN_CYCLES < int'(CNT_MAX)) ? WIN_CYCLES : int'(CNT_MAX);

    logic            last;
    cnt_t            acc;
    cnt_t            acc_next;
    grp_cfg_t        cfg [NGRP];
    logic [NGRP-1:0] hit;

    assign cfg[0] = unpack_cfg(exp0_lo, exp0_hi, tol_byte[TOL_W-1:0]);
    assign cfg[1] = unpack_cfg(exp1_lo, exp1_hi, tol_byte[2*TOL_W-1:TOL_W]);

    fwc_window_ctrl #(.WIN_CYCLES(WIN_CYCLES)) u_ctrl (
        .clk    (clk),
        .rst    (rst),
        .hold_i (restart),
        .last_o (last)
    );

    fwc_edge_counter u_cnt (
        .clk    (clk),
        .rst    (rst),
        .clr_i  (restart || last),
        .inc_i  (osc_pulse),
        .acc_o  (acc),
        .next_o (acc_next)
    );

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        fwc_group_cmp u_cmp (
            .cfg_i (cfg[g]),
            .cnt_i (acc_next),
            .hit_o (hit[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            done  <= 1'b0;
            count <= '0;
            match <= '0;
        end else begin
            done <= last;
            if (last) begin
                count <= acc_next;
                match <= hit;
            end
        end
    end

    assert_hold_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(restart) |-> (!done && match == '0 && count == '0));

    assert_done_pulse_R2: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        done |-> (count <= cnt_t'(BOUND)));

    assert_disabled_g0_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(restart) && !$past(exp0_hi[7])) |-> !match[0]);

    assert_disabled_g1_R6: assert property (@(posedge clk) disable iff (rst)
        (done && !$past(restart) && !$past(exp1_hi[7])) |-> !match[1]);

    assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!done && !$past(restart) && !$past(rst)) |-> ($stable(match) && $stable(count)));

    logic acc_unused;
    assign acc_unused = ^acc;
endmodule

// File: tb/test_freq_window_checker.sv
module test_freq_window_checker;
    localparam int WIN = 32;
    localparam int SAT_WIN = 33000;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic        rst = 1'b1, restart = 1'b1, osc = 1'b0;
    logic [7:0]  e0l = 0, e0h = 0, e1l = 0, e1h = 0, tol = 0;
    logic [1:0]  match;
    logic [14:0] count;
    logic        done;

    logic        rst_s = 1'b1, osc_s = 1'b0;
    logic [1:0]  match_s;
    logic [14:0] count_s;
    logic        done_s;

    int checks = 0, errors = 0, cycles = 0;
    bit sat_finished = 0, summary_done = 0;
    int prev_count = 0;
    logic [1:0] prev_match = 0;

    freq_window_checker #(.WIN_CYCLES(WIN)) i_freq_window_checker (
        .clk(clk), .rst(rst), .restart(restart), .osc_pulse(osc),
        .exp0_lo(e0l), .exp0_hi(e0h), .exp1_lo(e1l), .exp1_hi(e1h),
        .tol_byte(tol), .match(match), .count(count), .done(done));

    freq_window_checker #(.WIN_CYCLES(SAT_WIN)) i_freq_window_checker_sat (
        .clk(clk), .rst(rst_s), .restart(rst_s), .osc_pulse(osc_s),
        .exp0_lo(8'hFF), .exp0_hi(8'hFF), .exp1_lo(8'hFE), .exp1_hi(8'h7F),
        .tol_byte(8'h00), .match(match_s), .count(count_s), .done(done_s));

    function automatic bit exp_match(int cnt, logic [7:0] lo, logic [7:0] hi, logic [3:0] t);
        int e, d;
        if (!hi[7]) return 0;
        e = {hi[6:0], lo};
        d = (cnt > e) ? cnt - e : e - cnt;
        return d <= t;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!summary_done) begin
            summary_done = 1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Starts and ends at a negedge; pct = pulse probability in percent.
    task automatic run_window(input int pct, input string tag);
        int n = 0;
        bit early = 0, moved = 0;
        for (int i = 0; i < WIN; i++) begin
            osc = (($urandom % 100) < pct);
            n += int'(osc);
            @(posedge clk); #1;
            if (i < WIN - 1) begin
                if (done) early = 1;
                if (int'(count) != prev_count || match != prev_match) moved = 1;
            end else begin
                check(!early, {"R2 no early done ", tag}, int'(early), 0);
                check(done == 1'b1, {"R2 done at window end ", tag}, int'(done), 1);
                check(!moved, {"R9 results held ", tag}, int'(moved), 0);
                check(int'(count) == n, {"R3 count ", tag}, int'(count), n);
                check(match[0] == exp_match(n, e0l, e0h, tol[3:0]),
                      {"R5 R6 group0 ", tag}, int'(match[0]), int'(exp_match(n, e0l, e0h, tol[3:0])));
                check(match[1] == exp_match(n, e1l, e1h, tol[7:4]),
                      {"R5 R6 group1 ", tag}, int'(match[1]), int'(exp_match(n, e1l, e1h, tol[7:4])));
                prev_count = int'(count);
                prev_match = match;
            end
            @(negedge clk);
        end
        osc = 1'b0;
    endtask

    task automatic do_restart(input string tag);
        restart = 1'b1;
        @(posedge clk); #1;
        check(!done && match == 0 && count == 0, {"R1 restart clears ", tag}, int'(count), 0);
        @(negedge clk);
        restart = 1'b0;
        prev_count = 0;
        prev_match = 0;
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++;
                $display("FAIL watchdog actual %0d expected %0d", cycles, 100000);
                finish_run();
            end
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(negedge clk);
        check(!done && match == 0 && count == 0, "R1 reset state", int'(count), 0);
        rst = 1'b0;
        @(negedge clk);
        @(negedge clk);
        check(!done && match == 0 && count == 0, "R1 restart hold", int'(count), 0);
        restart = 1'b0;

        // R5 full window: count 32, limits on both sides, both nibbles
        tol = 8'h3F; e0h = 8'h80; e0l = 8'd47; e1h = 8'h80; e1l = 8'd35;
        run_window(100, "upper edge inclusive");
        e0l = 8'd48; e1l = 8'd36;
        run_window(100, "upper edge exclusive");
        e0l = 8'd17; e1l = 8'd29;
        run_window(100, "lower edge inclusive");
        e0l = 8'd16; e1l = 8'd28;
        run_window(100, "lower edge exclusive");
        // R4 high byte used; R6 disabled exact target
        e0h = 8'h81; e0l = 8'd32; e1h = 8'h00; e1l = 8'd32; tol = 8'hFF;
        run_window(100, "R4 high byte, R6 disabled");
        // empty window, exact zero target
        e0h = 8'h80; e0l = 8'd0; e1h = 8'h80; e1l = 8'd1; tol = 8'h00;
        run_window(0, "empty window");

        // R8 mid-window restart
        for (int i = 0; i < 10; i++) begin
            osc = 1'b1; @(negedge clk);
        end
        osc = 1'b0;
        do_restart("R8 mid-window");
        e0h = 8'h80; e0l = 8'd16; e1h = 8'h80; e1l = 8'd16; tol = 8'h21;
        run_window(50, "R8 fresh window");

        // random windows
        for (int k = 0; k < 24; k++) begin
            int base;
            base = $urandom % 33;
            e0h = {1'($urandom % 4 != 0), 7'd0};
            e1h = {1'($urandom % 4 != 0), 7'($urandom % 2 == 0 ? 0 : 1)};
            e0l = 8'(base + ($urandom % 9) - 4);
            e1l = 8'(base + ($urandom % 9) - 4);
            tol = 8'($urandom);
            run_window($urandom % 101, "random");
            if (k == 11) do_restart("random mid-run");
        end

        wait (sat_finished);
        finish_run();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_s = 1'b0;
        osc_s = 1'b1;
        for (int i = 0; i < SAT_WIN; i++) begin
            @(posedge clk); #1;
        end
        check(done_s == 1'b1, "R2 long window done", int'(done_s), 1);
        check(count_s == 15'h7FFF, "R7 saturated count", int'(count_s), 32767);
        check(match_s == 2'b01, "R7 saturated match", int'(match_s), 1);
        sat_finished = 1;
    end
endmodule